// File: doc/BRIEF.md
# Store Buffer with Load Forwarding and Fence

This block sits between a processor's memory port and a cache. Stores are written into a small in-order queue and leave it one per cycle, oldest first, whenever the cache write port is ready. Stores therefore retire on the processor side without waiting for the cache. Loads do not wait behind them. A load searches the queue. If one or more pending stores target the same address, the load takes the data of the youngest of them. Otherwise the load reads the cache directly, ahead of the older stores that are still queued.

Two controls bring back stronger ordering when software needs it. A fence request stalls the processor port until every queued store has been written to the cache. A strict-ordering mode input makes every load wait until the queue is empty, so loads and stores complete in program order. The cache read port is combinational: a read issued in a cycle returns its data in that same cycle. For this reason a load is never left outstanding across cycles.

Top module: `store_buffer`

## Requirements
- R1: After reset the queue is empty: `st_ready` is 1, `ld_ready` is 1, `c_wr_valid` is 0 and `fence_done` is 0.
- R2: A store is accepted on a cycle with `st_valid` and `st_ready` both high. `st_ready` is low while the queue holds DEPTH entries (default 4).
- R3: Queued stores go to the cache in the order they were accepted, at most one per cycle. The oldest entry is presented on `c_wr_addr`/`c_wr_data` with `c_wr_valid` high, and it stays unchanged until `c_wr_ready` accepts it. Stores to the same address therefore reach the cache in program order.
- R4: In relaxed mode (`strict_mode`=0), a load to an address that matches no queued store completes in the cycle it is presented. It does so with `c_rd_en`=1 and `ld_data` equal to `c_rd_data`, while the older stores remain queued.
- R5: A load whose address matches a queued store returns that store's data on `ld_data`, with `c_rd_en`=0.
- R6: When several queued stores hold the load's address, the load returns the data of the most recently accepted one.
- R7: A store accepted in the same cycle as a load is younger than that load. It does not forward to that load, but it does forward to loads in later cycles.
- R8: With `strict_mode`=1, `ld_ready` is low while any store is queued. It goes high in the cycle after the last store is accepted by the cache.
- R9: While `fence_req` is high, `st_ready` and `ld_ready` are low. `fence_done` is high exactly in the cycles where `fence_req` is high and the queue is empty, so it first rises in the cycle after the last queued store is accepted by the cache.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strict_mode | input | 1 | 1: loads wait for an empty queue |
| st_valid | input | 1 | Processor store request |
| st_ready | output | 1 | Store can be accepted |
| st_addr | input | ADDR_W (16) | Store address |
| st_data | input | DATA_W (32) | Store data |
| ld_valid | input | 1 | Processor load request |
| ld_ready | output | 1 | Load completes this cycle |
| ld_addr | input | ADDR_W (16) | Load address |
| ld_data | output | DATA_W (32) | Load result, valid when ld_valid and ld_ready |
| fence_req | input | 1 | Fence pending; held until fence_done |
| fence_done | output | 1 | All earlier stores are in the cache |
| c_wr_valid | output | 1 | Cache write request (oldest entry) |
| c_wr_ready | input | 1 | Cache accepts the write this cycle |
| c_wr_addr | output | ADDR_W (16) | Cache write address |
| c_wr_data | output | DATA_W (32) | Cache write data |
| c_rd_en | output | 1 | Cache read request |
| c_rd_addr | output | ADDR_W (16) | Cache read address |
| c_rd_data | input | DATA_W (32) | Cache read data, same cycle as c_rd_en |

## Verification
The embedded properties rely on three assumptions about the inputs. The cache returns read data combinationally. `c_wr_ready` may change freely from cycle to cycle. The processor leaves `fence_req` high until it sees `fence_done`. The bench keeps within these assumptions in the following way. A combinational cache model derives the read data from the read address. All requests change only at the falling clock edge. Fences are dropped only after `fence_done` has been observed. Drain stalls are created by holding `c_wr_ready` low over several cycles, which exercises the rule that the head entry must be held stable.

// File: rtl/sb_pkg.sv
package sb_pkg;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        addr_t addr;
        data_t data;
    } sb_entry_t;

    function automatic logic addr_match(input addr_t a, input addr_t b);
        return a == b;
    endfunction
endpackage

// File: rtl/sb_queue.sv
module sb_queue
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        push,
    input  sb_entry_t                   push_ent,
    input  logic                        pop,
    output sb_entry_t [DEPTH-1:0]       ents,
    output logic [PTR_W-1:0]            head_ptr,
    output logic [CNT_W-1:0]            count
);
    sb_entry_t [DEPTH-1:0] mem_q;
    logic [PTR_W-1:0]      tail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_ptr <= '0;
            tail_q   <= '0;
            count    <= '0;
        end else begin
            if (push) begin
                mem_q[tail_q] <= push_ent;
                tail_q        <= tail_q + 1'b1;
            end
            if (pop) head_ptr <= head_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign ents = mem_q;

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        push |-> (count < CNT_W'(DEPTH)));

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));

    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
endmodule

// File: rtl/sb_fwd.sv
module sb_fwd
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  sb_entry_t [DEPTH-1:0] ents,
    input  logic [PTR_W-1:0]      head_ptr,
    input  logic [CNT_W-1:0]      count,
    input  addr_t                 ld_addr,
    output logic                  hit,
    output data_t                 hit_data
);
    logic [PTR_W-1:0] idx;

    // Scan from oldest to youngest; a later match overrides, so the youngest wins.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        idx      = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_ptr + PTR_W'(k);
            if ((CNT_W'(k) < count) && addr_match(ents[idx].addr, ld_addr)) begin
                hit      = 1'b1;
                hit_data = ents[idx].data;
            end
        end
    end

    p_hit_needs_entry_r5: assert property (@(posedge clk) disable iff (rst)
        hit |-> (count != '0));
endmodule

// File: rtl/store_buffer.sv
module store_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strict_mode,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              ld_valid,
    output logic              ld_ready,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [DATA_W-1:0] ld_data,
    input  logic              fence_req,
    output logic              fence_done,
    output logic              c_wr_valid,
    input  logic              c_wr_ready,
    output logic [ADDR_W-1:0] c_wr_addr,
    output logic [DATA_W-1:0] c_wr_data,
    output logic              c_rd_en,
    output logic [ADDR_W-1:0] c_rd_addr,
    input  logic [DATA_W-1:0] c_rd_data
);
    sb_entry_t [DEPTH-1:0] ents;
    logic [PTR_W-1:0]      head_ptr;
    logic [CNT_W-1:0]      count;
    logic                  empty, full, push, pop, fwd_hit, ld_fire;
    data_t                 fwd_data;
    sb_entry_t             push_ent;

    assign empty    = (count == '0);
    assign full     = (count == CNT_W'(DEPTH));
    assign st_ready = !full && !fence_req;
    assign push     = st_valid && st_ready;
    assign push_ent = '{addr: st_addr, data: st_data};

    assign c_wr_valid = !empty;
    assign c_wr_addr  = ents[head_ptr].addr;
    assign c_wr_data  = ents[head_ptr].data;
    assign pop        = c_wr_valid && c_wr_ready;

    assign ld_ready   = !fence_req && (!strict_mode || empty);
    assign ld_fire    = ld_valid && ld_ready;
    assign c_rd_en    = ld_fire && !fwd_hit;
    assign c_rd_addr  = ld_addr;
    assign ld_data    = fwd_hit ? fwd_data : c_rd_data;

    assign fence_done = fence_req && empty;

    sb_queue #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (push_ent),
        .pop      (pop),
        .ents     (ents),
        .head_ptr (head_ptr),
        .count    (count)
    );

    sb_fwd #(.DEPTH(DEPTH)) u_fwd (
        .clk      (clk),
        .rst      (rst),
        .ents     (ents),
        .head_ptr (head_ptr),
        .count    (count),
        .ld_addr  (ld_addr),
        .hit      (fwd_hit),
        .hit_data (fwd_data)
    );

    p_head_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (c_wr_valid && !c_wr_ready) |=> (c_wr_valid && $stable(c_wr_addr) && $stable(c_wr_data)));

    p_strict_order_r8: assert property (@(posedge clk) disable iff (rst)
        (strict_mode && ld_fire) |-> !c_wr_valid);

    p_fence_drained_r9: assert property (@(posedge clk) disable iff (rst)
        fence_done |-> !c_wr_valid);

    p_fence_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        fence_req |-> (!push && !ld_fire));
endmodule

// File: tb/store_buffer_tb.sv
module store_buffer_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        strict_mode, st_valid, st_ready, ld_valid, ld_ready;
    logic [15:0] st_addr, ld_addr, c_wr_addr, c_rd_addr;
    logic [31:0] st_data, ld_data, c_wr_data, c_rd_data;
    logic        fence_req, fence_done, c_wr_valid, c_wr_ready, c_rd_en;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;   // 50 MHz

    // Combinational cache model: data derived from address
    assign c_rd_data = {16'hCAFE, c_rd_addr};

    store_buffer u_dut (
        .clk(clk), .rst(rst), .strict_mode(strict_mode),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data),
        .fence_req(fence_req), .fence_done(fence_done),
        .c_wr_valid(c_wr_valid), .c_wr_ready(c_wr_ready),
        .c_wr_addr(c_wr_addr), .c_wr_data(c_wr_data),
        .c_rd_en(c_rd_en), .c_rd_addr(c_rd_addr), .c_rd_data(c_rd_data)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic        exp_hit;
        logic [31:0] exp_data;
    } ld_vec_t;

    // Queue holds (oldest first): 0010/A1, 0020/B2, 0010/C3, 0030/D4
    localparam ld_vec_t VECS [5] = '{
        '{addr: 16'h0010, exp_hit: 1'b1, exp_data: 32'h0000_00C3},  // R6 youngest
        '{addr: 16'h0020, exp_hit: 1'b1, exp_data: 32'h0000_00B2},  // R5
        '{addr: 16'h0030, exp_hit: 1'b1, exp_data: 32'h0000_00D4},  // R5
        '{addr: 16'h0040, exp_hit: 1'b0, exp_data: 32'hCAFE_0040},  // R4
        '{addr: 16'h0000, exp_hit: 1'b0, exp_data: 32'hCAFE_0000}   // R4
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_store(input logic [15:0] a, input logic [31:0] d);
        st_valid = 1'b1; st_addr = a; st_data = d;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_tests++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; strict_mode = 1'b0; st_valid = 1'b0; ld_valid = 1'b0;
        st_addr = '0; st_data = '0; ld_addr = '0; fence_req = 1'b0; c_wr_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R1 reset state
        chk("R1 st_ready", 32'(st_ready), 32'd1);
        chk("R1 ld_ready", 32'(ld_ready), 32'd1);
        chk("R1 c_wr_valid", 32'(c_wr_valid), 32'd0);
        chk("R1 fence_done", 32'(fence_done), 32'd0);

        @(negedge clk);
        push_store(16'h0010, 32'hA1);
        push_store(16'h0020, 32'hB2);
        push_store(16'h0010, 32'hC3);
        chk("R2 ready before full", 32'(st_ready), 32'd1);
        push_store(16'h0030, 32'hD4);
        #2;
        chk("R2 st_ready when full", 32'(st_ready), 32'd0);
        chk("R3 head addr held", 32'(c_wr_addr), 32'h0010);
        @(negedge clk); #2;
        chk("R3 head data held", c_wr_data, 32'hA1);

        // table of loads against the full queue
        foreach (VECS[i]) begin
            ld_valid = 1'b1; ld_addr = VECS[i].addr;
            #2;
            chk($sformatf("R4/R5/R6 ld_data vec%0d", i), ld_data, VECS[i].exp_data);
            chk($sformatf("R4/R5 c_rd_en vec%0d", i), 32'(c_rd_en), 32'(!VECS[i].exp_hit));
            @(negedge clk);
        end
        ld_valid = 1'b0;

        // R3 drain in order, one per cycle
        c_wr_ready = 1'b1;
        #2;
        chk("R3 drain0 addr", 32'(c_wr_addr), 32'h0010); chk("R3 drain0 data", c_wr_data, 32'hA1);
        @(negedge clk); #2;
        chk("R3 drain1 addr", 32'(c_wr_addr), 32'h0020); chk("R3 drain1 data", c_wr_data, 32'hB2);
        @(negedge clk); #2;
        chk("R3 drain2 addr", 32'(c_wr_addr), 32'h0010); chk("R3 drain2 data", c_wr_data, 32'hC3);
        @(negedge clk); #2;
        chk("R3 drain3 addr", 32'(c_wr_addr), 32'h0030); chk("R3 drain3 data", c_wr_data, 32'hD4);
        @(negedge clk); #2;
        chk("R3 drained", 32'(c_wr_valid), 32'd0);

        // R7 same-cycle store is younger than the load
        @(negedge clk);
        c_wr_ready = 1'b0;
        st_valid = 1'b1; st_addr = 16'h0050; st_data = 32'h55;
        ld_valid = 1'b1; ld_addr = 16'h0050;
        #2;
        chk("R7 same-cycle ld_data", ld_data, 32'hCAFE_0050);
        chk("R7 same-cycle c_rd_en", 32'(c_rd_en), 32'd1);
        @(negedge clk);
        st_valid = 1'b0;
        #2;
        chk("R7 later load forwards", ld_data, 32'h55);
        ld_valid = 1'b0;

        // R8 strict mode
        strict_mode = 1'b1;
        #2;
        chk("R8 ld_ready blocked", 32'(ld_ready), 32'd0);
        c_wr_ready = 1'b1;
        @(negedge clk); #2;
        chk("R8 ld_ready after drain", 32'(ld_ready), 32'd1);
        strict_mode = 1'b0;
        c_wr_ready = 1'b0;

        // R9 fence
        @(negedge clk);
        push_store(16'h0060, 32'h66);
        push_store(16'h0070, 32'h77);
        fence_req = 1'b1;
        #2;
        chk("R9 fence_done busy", 32'(fence_done), 32'd0);
        chk("R9 st_ready blocked", 32'(st_ready), 32'd0);
        chk("R9 ld_ready blocked", 32'(ld_ready), 32'd0);
        c_wr_ready = 1'b1;
        @(negedge clk); #2;
        chk("R9 fence_done one left", 32'(fence_done), 32'd0);
        @(negedge clk); #2;
        chk("R9 fence_done empty", 32'(fence_done), 32'd1);
        fence_req = 1'b0;
        #2;
        chk("R9 fence_done dropped", 32'(fence_done), 32'd0);
        chk("R9 st_ready restored", 32'(st_ready), 32'd1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule